// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register Block

This block holds the control and status words that software uses to steer the descriptor-based DMA engines of an Ethernet controller. The words are the DMA status word, the interrupt enable mask, the bus mode word, the receive and transmit ring base addresses, and the two current-descriptor pointers. Software reaches them over a simple word-addressed register bus. The transmit and receive engines report completion and buffer shortage through single-cycle event inputs, and these events set bits in the status word.

The block combines status and enable into one level-sensitive interrupt line. Some writes do more than store a value. Clearing status uses write-one-to-clear. Programming a ring base also rewinds the matching current pointer. A write to the transmit kick location produces a one-cycle start pulse and stores nothing.

Top module: `dma_csr_block`

## Requirements
- R1: `irq` is a registered output that is high exactly when the bitwise AND of the status word and the interrupt enable word (word index 0x3C7) is nonzero. It takes its new value at the same clock edge that updates either word.
- R2: A write to the status word (word index 0x3C5) clears each status bit whose write-data bit is 1 and leaves every other bit unchanged.
- R3: `ev_tx_done` sets status bits 0 and 16. `ev_rx_done` sets bits 6 and 16. `ev_rx_nobuf` sets bits 7 and 15. An event that arrives in the same cycle as a clearing status write still leaves its bits set.
- R4: A write to the receive ring base (index 0x3C3) stores the value there and also in the current receive pointer (index 0x3D3). A write to the transmit ring base (index 0x3C4) does the same for the current transmit pointer (index 0x3D2).
- R5: A write to the bus mode word (index 0x3C0) stores the write data with bit 0 forced to 0.
- R6: A write to the transmit kick location (index 0x3C1) drives `tx_poll` high for exactly the one cycle after the write edge. The location stores nothing and reads as zero.
- R7: The version location (index 0x08) always reads 0x00001012, and writes to it have no effect.
- R8: The word index is the byte address shifted right by two. Any index at or above 0x400 reads as zero and is ignored on write. Indices that hold no register also read as zero.
- R9: After reset every stored word is zero, and `irq` and `tx_poll` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | ADDR_W | Byte address of the access |
| csr_wr | input | 1 | Write strobe for one cycle |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Read data for `csr_addr`, combinational |
| ev_tx_done | input | 1 | Transmit engine finished a frame |
| ev_rx_done | input | 1 | Receive engine stored a frame |
| ev_rx_nobuf | input | 1 | Receive engine found no free descriptor |
| irq | output | 1 | Level interrupt |
| tx_poll | output | 1 | One-cycle start pulse toward the transmit engine |

## Verification
Several properties are checked on every clock cycle. The interrupt must track the masked status, and write-one-to-clear must work bit by bit. Events must win over clears, base writes must rewind their pointers, and bus mode bit 0 must drop. Kick writes must raise the pulse, and out-of-range writes must leave stored words alone. Other behaviour shows only in the bench scenarios, because it concerns what a read returns. These include the fixed version value, the zero read-back of the kick location and of unmapped or aliased indices, and the exact status patterns seen from software after each kind of event.

// File: rtl/dma_csr_block.sv
module dma_csr_block #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_LIMIT = 1024,
  parameter logic [DATA_W-1:0] VERSION_WORD = DATA_W'(32'h1012)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_wr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              ev_tx_done,
  input  logic              ev_rx_done,
  input  logic              ev_rx_nobuf,
  output logic              irq,
  output logic              tx_poll
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IX_VER    = IDX_W'(10'h008);
  localparam logic [IDX_W-1:0] IX_BMODE  = IDX_W'(10'h3C0);
  localparam logic [IDX_W-1:0] IX_KICK   = IDX_W'(10'h3C1);
  localparam logic [IDX_W-1:0] IX_RXBASE = IDX_W'(10'h3C3);
  localparam logic [IDX_W-1:0] IX_TXBASE = IDX_W'(10'h3C4);
  localparam logic [IDX_W-1:0] IX_STAT   = IDX_W'(10'h3C5);
  localparam logic [IDX_W-1:0] IX_IEN    = IDX_W'(10'h3C7);
  localparam logic [IDX_W-1:0] IX_CURTX  = IDX_W'(10'h3D2);
  localparam logic [IDX_W-1:0] IX_CURRX  = IDX_W'(10'h3D3);
  localparam logic [IDX_W-1:0] IX_LIMIT  = IDX_W'(IDX_LIMIT);

  logic [IDX_W-1:0]  idx;
  logic              in_range, unused_lsb;
  logic [DATA_W-1:0] status_q, status_d, ien_q, ien_d, ev_set;
  logic [DATA_W-1:0] bmode_q, rxbase_q, txbase_q, currx_q, curtx_q;

  assign idx        = csr_addr[ADDR_W-1:2];
  assign unused_lsb = ^csr_addr[1:0];
  assign in_range   = idx < IX_LIMIT;

  function automatic logic hit(input logic [IDX_W-1:0] k);
    return csr_wr && in_range && (idx == k);
  endfunction

  always_comb begin
    ev_set = '0;
    ev_set[0]  = ev_tx_done;
    ev_set[6]  = ev_rx_done;
    ev_set[7]  = ev_rx_nobuf;
    ev_set[15] = ev_rx_nobuf;
    ev_set[16] = ev_tx_done | ev_rx_done;
  end

  assign status_d = (hit(IX_STAT) ? (status_q & ~csr_wdata) : status_q) | ev_set;
  assign ien_d    = hit(IX_IEN) ? csr_wdata : ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      ien_q    <= '0;
      bmode_q  <= '0;
      rxbase_q <= '0;
      txbase_q <= '0;
      currx_q  <= '0;
      curtx_q  <= '0;
      irq      <= 1'b0;
      tx_poll  <= 1'b0;
    end else begin
      status_q <= status_d;
      ien_q    <= ien_d;
      irq      <= |(status_d & ien_d);
      tx_poll  <= hit(IX_KICK);
      if (hit(IX_BMODE)) bmode_q <= {csr_wdata[DATA_W-1:1], 1'b0};
      if (hit(IX_RXBASE)) begin
        rxbase_q <= csr_wdata;
        currx_q  <= csr_wdata;
      end
      if (hit(IX_TXBASE)) begin
        txbase_q <= csr_wdata;
        curtx_q  <= csr_wdata;
      end
      if (hit(IX_CURRX)) currx_q <= csr_wdata;
      if (hit(IX_CURTX)) curtx_q <= csr_wdata;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (in_range) begin
      case (idx)
        IX_VER:    csr_rdata = VERSION_WORD;
        IX_BMODE:  csr_rdata = bmode_q;
        IX_RXBASE: csr_rdata = rxbase_q;
        IX_TXBASE: csr_rdata = txbase_q;
        IX_STAT:   csr_rdata = status_q;
        IX_IEN:    csr_rdata = ien_q;
        IX_CURTX:  csr_rdata = curtx_q;
        IX_CURRX:  csr_rdata = currx_q;
        default:   csr_rdata = '0;
      endcase
    end
  end

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(status_q & ien_q)) else $error("irq mismatch"); // R1
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit(IX_STAT) && ev_set == '0) |=> status_q == ($past(status_q) & ~$past(csr_wdata)))
    else $error("w1c"); // R2
  AST_RX_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_done |=> (status_q[6] && status_q[16])) else $error("rx evt"); // R3
  AST_NOBUF_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_nobuf |=> (status_q[7] && status_q[15])) else $error("nobuf evt"); // R3
  AST_RX_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit(IX_RXBASE) |=> currx_q == $past(csr_wdata)) else $error("rx reload"); // R4
  AST_TX_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit(IX_TXBASE) |=> curtx_q == $past(csr_wdata)) else $error("tx reload"); // R4
  AST_BMODE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    hit(IX_BMODE) |=> bmode_q == {$past(csr_wdata[DATA_W-1:1]), 1'b0}) else $error("bmode"); // R5
  AST_KICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hit(IX_KICK) |=> tx_poll) else $error("kick"); // R6
  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !in_range) |=> ($stable(bmode_q) && $stable(ien_q) && $stable(rxbase_q)))
    else $error("oor write"); // R8
endmodule

// File: tb/tb_dma_csr_block.sv
module tb_dma_csr_block;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] csr_addr = '0;
  logic        csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        ev_tx_done = 1'b0, ev_rx_done = 1'b0, ev_rx_nobuf = 1'b0;
  logic        irq, tx_poll;
  int checks = 0, failures = 0;
  bit done = 0;

  localparam logic [15:0] A_VER = 16'h0020, A_BMODE = 16'hF00, A_KICK = 16'hF04,
    A_RXBASE = 16'hF0C, A_TXBASE = 16'hF10, A_STAT = 16'hF14, A_IEN = 16'hF1C,
    A_CURTX = 16'hF48, A_CURRX = 16'hF4C, A_UNMAP = 16'h0F08;

  always #10 clk = ~clk;

  dma_csr_block dut (.clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .ev_tx_done(ev_tx_done),
    .ev_rx_done(ev_rx_done), .ev_rx_nobuf(ev_rx_nobuf), .irq(irq), .tx_poll(tx_poll));

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  task automatic events(input logic t, input logic r, input logic n);
    @(negedge clk);
    ev_tx_done = t; ev_rx_done = r; ev_rx_nobuf = n;
    @(negedge clk);
    ev_tx_done = 0; ev_rx_done = 0; ev_rx_nobuf = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_STAT, v);  check("R9", "status after reset", v, 0);
    rd(A_RXBASE, v); check("R9", "rx base after reset", v, 0);
    check("R9", "irq after reset", {31'd0, irq}, 0);
    check("R9", "tx_poll after reset", {31'd0, tx_poll}, 0);
  endtask

  task automatic t_version;
    logic [31:0] v;
    rd(A_VER, v); check("R7", "version", v, 32'h1012);
    wr(A_VER, 32'hDEAD_BEEF);
    rd(A_VER, v); check("R7", "version after write", v, 32'h1012);
    rd(A_UNMAP, v); check("R8", "unmapped index", v, 0);
  endtask

  task automatic t_bmode;
    logic [31:0] v;
    wr(A_BMODE, 32'hFFFF_FFFF);
    rd(A_BMODE, v); check("R5", "bus mode lsb forced", v, 32'hFFFF_FFFE);
    wr(A_BMODE, 32'h0000_0081);
    rd(A_BMODE, v); check("R5", "bus mode second value", v, 32'h0000_0080);
  endtask

  task automatic t_bases;
    logic [31:0] v;
    wr(A_CURRX, 32'h0000_0777);
    rd(A_CURRX, v); check("R4", "cur rx direct write", v, 32'h0000_0777);
    wr(A_RXBASE, 32'h1000_0040);
    rd(A_RXBASE, v); check("R4", "rx base", v, 32'h1000_0040);
    rd(A_CURRX, v); check("R4", "cur rx reloaded", v, 32'h1000_0040);
    rd(A_CURTX, v); check("R4", "cur tx untouched", v, 0);
    wr(A_TXBASE, 32'h2000_0080);
    rd(A_CURTX, v); check("R4", "cur tx reloaded", v, 32'h2000_0080);
    rd(A_CURRX, v); check("R4", "cur rx kept", v, 32'h1000_0040);
  endtask

  task automatic t_kick;
    logic [31:0] v;
    @(negedge clk);
    csr_addr = A_KICK; csr_wdata = 32'hFFFF_FFFF; csr_wr = 1'b1;
    check("R6", "tx_poll before edge", {31'd0, tx_poll}, 0);
    @(negedge clk);
    csr_wr = 1'b0;
    check("R6", "tx_poll after write", {31'd0, tx_poll}, 1);
    @(negedge clk);
    check("R6", "tx_poll one cycle only", {31'd0, tx_poll}, 0);
    rd(A_KICK, v); check("R6", "kick reads zero", v, 0);
  endtask

  task automatic t_status_irq;
    logic [31:0] v;
    events(1, 0, 0);
    rd(A_STAT, v); check("R3", "tx done bits", v, 32'h0001_0001);
    check("R1", "irq masked", {31'd0, irq}, 0);
    wr(A_IEN, 32'h0000_0001);
    check("R1", "irq after enable", {31'd0, irq}, 1);
    wr(A_STAT, 32'h0000_0001);
    rd(A_STAT, v); check("R2", "clear bit 0 only", v, 32'h0001_0000);
    check("R1", "irq after clear", {31'd0, irq}, 0);
    wr(A_IEN, 32'h0001_0000);
    check("R1", "irq on summary", {31'd0, irq}, 1);
    wr(A_STAT, 32'h0001_0000);
    check("R1", "irq drops", {31'd0, irq}, 0);
    events(0, 0, 1);
    rd(A_STAT, v); check("R3", "no buffer bits", v, 32'h0000_8080);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R2", "clear all", v, 0);
    events(0, 1, 0);
    rd(A_STAT, v); check("R3", "rx done bits", v, 32'h0001_0040);
    check("R1", "irq on rx summary", {31'd0, irq}, 1);
    wr(A_STAT, 32'hFFFF_FFFF);
    @(negedge clk);
    csr_addr = A_STAT; csr_wdata = 32'hFFFF_FFFF; csr_wr = 1'b1; ev_rx_done = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0; ev_rx_done = 1'b0;
    rd(A_STAT, v); check("R3", "event beats clear", v, 32'h0001_0040);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_range;
    logic [31:0] v;
    events(1, 0, 0);
    wr(16'h1F14, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R8", "aliased status write ignored", v, 32'h0001_0001);
    rd(16'h1F14, v); check("R8", "out of range reads zero", v, 0);
    wr(16'h1F00, 32'h0000_0055);
    rd(A_BMODE, v); check("R8", "aliased bus mode ignored", v, 32'h0000_0080);
    rd(16'h1F00, v); check("R8", "out of range bus mode read", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_version();
    t_bmode();
    t_bases();
    t_kick();
    t_status_irq();
    t_range();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule